// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix-Multiply Grid

This block multiplies an integer tile A (ROWS × K) by a tile B (K × COLS) on a grid of processing elements. Each element is wired only to its nearest neighbours. Each element keeps one result C[i][j] in a local accumulator. Operands move through the grid: A moves one column to the right per clock, and B moves one row down per clock. Each element has a SIMD dot-product cell with LANES lanes, so one valid beat carries LANES packed operand pairs. The element adds the dot product of those pairs to its accumulator. A tile of depth K therefore takes K/LANES beats.

A feeder outside the block drives row i of A onto the left edge delayed by i cycles, and column j of B onto the top edge delayed by j cycles. With this skew, matching k indices meet at every element. A start pulse clears all accumulators and begins a job. Each element counts the beats in which both of its operands are valid, and it reports done after K/LANES such beats. A central controller waits until every element is done. It then shifts the accumulators down through per-column chains and presents one full row per cycle on the output port, with a valid flag and a row index.

Top module: `smg_array`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `out_valid` are 0.
- R2: Each result equals the exact signed sum over k of A[i][k]·B[k][j] for W-bit two's-complement operands. The sum is held in ACC_W = 2·W + clog2(K) bits and never wraps. Lane l of row i is `a_data[(i*LANES+l)*W +: W]` and carries A[i][beat*LANES+l]. Lane l of column j is `b_data[(j*LANES+l)*W +: W]` and carries B[beat*LANES+l][j]. Column j of a result row is `out_data[j*ACC_W +: ACC_W]`.
- R3: Suppose start is sampled on one edge, and the first beat of row 0 and column 0 is sampled on edge 0. Then, with uninterrupted skewed feeding, `out_valid` first reads 1 right after edge ROWS+COLS+K/LANES−2.
- R4: A drain lasts exactly ROWS consecutive cycles. It delivers the bottom row first, with `out_row` counting down from ROWS−1 to 0. `out_valid` is 0 at every other time.
- R5: An accepted start clears every accumulator and beat count, so a job's results carry nothing from the job before it.
- R6: An element accumulates only in cycles where both of its operand valids are high. If the feeder inserts an N-cycle bubble into every row and column, the output is unchanged and is delivered N cycles later.
- R7: Once an element has taken K/LANES beats, further valid beats have no effect on its result.
- R8: A start that arrives while a drain is in progress is ignored. The drain continues with correct values, and no new job begins.
- R9: `busy` is 1 from the cycle after an accepted start until the last drain cycle, and is 0 once the drain has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clear accumulators and begin a job |
| a_valid | input | ROWS | Per-row valid for the left-edge operand beat |
| a_data | input | ROWS*LANES*W | Packed A lanes, one group per row |
| b_valid | input | COLS | Per-column valid for the top-edge operand beat |
| b_data | input | COLS*LANES*W | Packed B lanes, one group per column |
| busy | output | 1 | Job in progress, including the drain |
| out_valid | output | 1 | A result row is on `out_data` |
| out_row | output | ROW_W | Index of the row on `out_data` |
| out_data | output | COLS*ACC_W | Result row, one ACC_W field per column |

## Verification
Each beat takes one cycle per hop, so element (i,j) takes its k-th beat on edge i+j+k. The drain therefore starts right after edge ROWS+COLS+K/LANES−2, moved later by any bubble. The bench works out that edge for every job and records the loop step of each sample. It compares each drained row against the step it expected, and it checks that `out_valid` is 0 at all other steps. Inputs change at the falling edge and outputs are read at the next falling edge, so each sample shows the state after exactly one rising edge.

// File: rtl/smg_pkg.sv
// Shared types for the systolic matrix-multiply grid.
package smg_pkg;

    // Controller phases: waiting, accumulating, draining results.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } smg_state_e;

endpackage

// File: rtl/smg_dot_cell.sv
// SIMD dot-product cell: multiplies LANES signed W-bit pairs and adds the
// products, sign-extended to OUT_W. Purely combinational.
// Assumes OUT_W >= 2*W + clog2(LANES).
module smg_dot_cell #(
    parameter int W     = 8,
    parameter int LANES = 2,
    parameter int OUT_W = 19
) (
    input  logic [LANES*W-1:0]       a_vec,
    input  logic [LANES*W-1:0]       b_vec,
    output logic signed [OUT_W-1:0]  dot
);

    logic signed [2*W-1:0] prod [LANES];

    // One signed multiplier per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign prod[l] = $signed(a_vec[l*W +: W]) * $signed(b_vec[l*W +: W]);
    end

    // Adder tree written as a chain; each term is sign-extended first.
    always_comb begin
        logic signed [OUT_W-1:0] sum;
        logic signed [OUT_W-1:0] ext;
        sum = '0;
        for (int l = 0; l < LANES; l++) begin
            ext = prod[l];
            sum = sum + ext;
        end
        dot = sum;
    end

endmodule

// File: rtl/smg_pe.sv
// Processing element: forwards A right and B down one cycle later with
// their valids, and accumulates the lane dot product when both valids are
// high, enabled, and fewer than BEATS beats have been taken. During a
// drain its accumulator takes the value of the element above it.
// Assumes clr takes priority over shift and accumulation.
module smg_pe #(
    parameter int W     = 8,
    parameter int LANES = 2,
    parameter int ACC_W = 19,
    parameter int BEATS = 3,
    localparam int CNT_W = $clog2(BEATS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    shift,
    input  logic [LANES*W-1:0]      a_in,
    input  logic                    a_vin,
    input  logic [LANES*W-1:0]      b_in,
    input  logic                    b_vin,
    input  logic [ACC_W-1:0]        acc_above,
    output logic [LANES*W-1:0]      a_out,
    output logic                    a_vout,
    output logic [LANES*W-1:0]      b_out,
    output logic                    b_vout,
    output logic [ACC_W-1:0]        acc_out,
    output logic                    done
);

    logic signed [ACC_W-1:0] dot;
    logic signed [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    fire;

    smg_dot_cell #(.W(W), .LANES(LANES), .OUT_W(ACC_W)) u_cell (
        .a_vec (a_in),
        .b_vec (b_in),
        .dot   (dot)
    );

    assign done    = (cnt_q == CNT_W'(BEATS));
    assign fire    = en && a_vin && b_vin && !done;
    assign acc_out = acc_q;

    // Operand pipeline registers toward the right and lower neighbours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out  <= '0;
            a_vout <= 1'b0;
            b_out  <= '0;
            b_vout <= 1'b0;
        end else begin
            a_out  <= a_in;
            a_vout <= a_vin;
            b_out  <= b_in;
            b_vout <= b_vin;
        end
    end

    // Accumulator and beat counter: clear, drain shift, or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (shift) begin
            acc_q <= acc_above;
        end else if (fire) begin
            acc_q <= acc_q + dot;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    logic [ACC_W:0] wide_sum;
    assign wide_sum = {acc_q[ACC_W-1], acc_q} + {dot[ACC_W-1], dot};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !clr && !shift |-> wide_sum[ACC_W] == wide_sum[ACC_W-1]); // R2
    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BEATS)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr |=> done); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_q == '0 && cnt_q == '0); // R5

endmodule

// File: rtl/smg_ctrl.sv
// Central controller: accepts start outside a drain, enables accumulation
// until every element reports done, then runs a ROWS-cycle drain that
// shifts results down and flags each row on the output.
// Assumes all_done is the AND of every element's done flag.
module smg_ctrl
    import smg_pkg::*;
#(
    parameter int ROWS = 3,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             all_done,
    output logic             clr,
    output logic             en,
    output logic             shift,
    output logic             busy,
    output logic             out_valid,
    output logic [ROW_W-1:0] out_row
);

    smg_state_e       state_q;
    logic [ROW_W-1:0] row_q;

    assign clr       = start && (state_q != ST_DRAIN);
    assign en        = (state_q == ST_RUN);
    assign shift     = (state_q == ST_DRAIN);
    assign busy      = (state_q != ST_IDLE);
    assign out_valid = (state_q == ST_DRAIN);
    assign out_row   = ROW_W'(ROWS - 1) - row_q;

    // Phase sequencing and drain row counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (!start && all_done) begin
                        state_q <= ST_DRAIN;
                        row_q   <= '0;
                    end
                end
                ST_DRAIN: begin
                    row_q <= row_q + 1'b1;
                    if (row_q == ROW_W'(ROWS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) && start |=> state_q != ST_RUN); // R8
    AST_DRAIN_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> row_q <= ROW_W'(ROWS - 1)); // R4
    AST_DRAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(all_done) && out_row == ROW_W'(ROWS - 1)); // R4

endmodule

// File: rtl/smg_array.sv
// Top of the output-stationary grid: ROWS x COLS processing elements
// with nearest-neighbour links, edge feeder inputs, and a bottom-row
// collector output. Assumes K is a multiple of LANES and the external
// feeder skews row i and column j by i and j cycles.
module smg_array
    import smg_pkg::*;
#(
    parameter int ROWS  = 3,
    parameter int COLS  = 2,
    parameter int W     = 8,
    parameter int LANES = 2,
    parameter int K     = 6,
    localparam int BEATS = K / LANES,
    localparam int ACC_W = 2 * W + $clog2(K),
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int VEC_W = LANES * W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ROWS-1:0]         a_valid,
    input  logic [ROWS*VEC_W-1:0]   a_data,
    input  logic [COLS-1:0]         b_valid,
    input  logic [COLS*VEC_W-1:0]   b_data,
    output logic                    busy,
    output logic                    out_valid,
    output logic [ROW_W-1:0]        out_row,
    output logic [COLS*ACC_W-1:0]   out_data
);

    logic [VEC_W-1:0] a_lnk  [ROWS][COLS+1];
    logic             av_lnk [ROWS][COLS+1];
    logic [VEC_W-1:0] b_lnk  [ROWS+1][COLS];
    logic             bv_lnk [ROWS+1][COLS];
    logic [ACC_W-1:0] acc_lnk [ROWS+1][COLS];
    logic [ROWS*COLS-1:0] done_vec;
    logic clr, en, shift;

    // Left-edge feeders.
    for (genvar i = 0; i < ROWS; i++) begin : g_left
        assign a_lnk[i][0]  = a_data[i*VEC_W +: VEC_W];
        assign av_lnk[i][0] = a_valid[i];
    end

    // Top-edge feeders, the zero source of the drain chains, and the collector.
    for (genvar j = 0; j < COLS; j++) begin : g_top
        assign b_lnk[0][j]   = b_data[j*VEC_W +: VEC_W];
        assign bv_lnk[0][j]  = b_valid[j];
        assign acc_lnk[0][j] = '0;
        assign out_data[j*ACC_W +: ACC_W] = acc_lnk[ROWS][j];
    end

    // The grid of processing elements.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar j = 0; j < COLS; j++) begin : g_col
            smg_pe #(.W(W), .LANES(LANES), .ACC_W(ACC_W), .BEATS(BEATS)) u_pe (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (clr),
                .en        (en),
                .shift     (shift),
                .a_in      (a_lnk[i][j]),
                .a_vin     (av_lnk[i][j]),
                .b_in      (b_lnk[i][j]),
                .b_vin     (bv_lnk[i][j]),
                .acc_above (acc_lnk[i][j]),
                .a_out     (a_lnk[i][j+1]),
                .a_vout    (av_lnk[i][j+1]),
                .b_out     (b_lnk[i+1][j]),
                .b_vout    (bv_lnk[i+1][j]),
                .acc_out   (acc_lnk[i+1][j]),
                .done      (done_vec[i*COLS + j])
            );
        end
    end

    smg_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .all_done  (&done_vec),
        .clr       (clr),
        .en        (en),
        .shift     (shift),
        .busy      (busy),
        .out_valid (out_valid),
        .out_row   (out_row)
    );

    AST_BUSY_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R9
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_row < ROW_W'(ROWS)); // R4

endmodule

// File: tb/tb_smg_array.sv
// Sweeps several operand patterns, bubbles, surplus beats and a start
// during the drain, and compares every drained row, its index and its cycle.
module tb_smg_array;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 3;
    localparam int COLS  = 2;
    localparam int W     = 8;
    localparam int LANES = 2;
    localparam int K     = 6;
    localparam int BEATS = K / LANES;
    localparam int ACC_W = 2 * W + $clog2(K);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int VEC_W = LANES * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ROWS-1:0]       a_valid = '0;
    logic [ROWS*VEC_W-1:0] a_data  = '0;
    logic [COLS-1:0]       b_valid = '0;
    logic [COLS*VEC_W-1:0] b_data  = '0;
    logic busy, out_valid;
    logic [ROW_W-1:0]      out_row;
    logic [COLS*ACC_W-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    int amat [ROWS][K];
    int bmat [K][COLS];
    int seed = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    smg_array #(.ROWS(ROWS), .COLS(COLS), .W(W), .LANES(LANES), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
        .busy(busy), .out_valid(out_valid), .out_row(out_row), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 255) - 128;
    endfunction

    // mode 0: pseudo-random, 1: all -128, 2: A=-128 and B=127
    task automatic fill(input int mode);
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < K; k++)
                amat[i][k] = (mode == 0) ? next_rand() : -128;
        for (int k = 0; k < K; k++)
            for (int j = 0; j < COLS; j++)
                bmat[k][j] = (mode == 0) ? next_rand() : ((mode == 1) ? -128 : 127);
    endtask

    // Map a step and a skew to a beat index, or -1 if no beat is due.
    function automatic int beat_at(input int t, input int skew, input int extra,
                                   input int gap_at, input int gap_len);
        int rel;
        rel = t - skew;
        if (rel < 0) return -1;
        if (rel >= gap_at && rel < gap_at + gap_len) return -1;
        if (rel >= gap_at + gap_len) rel = rel - gap_len;
        if (rel < BEATS + extra) return rel;
        return -1;
    endfunction

    task automatic drive(input int t, input int extra, input int gap_at,
                         input int gap_len, input int start_step);
        start = (t == start_step);
        for (int i = 0; i < ROWS; i++) begin
            int bt;
            bt = beat_at(t, i, extra, gap_at, gap_len);
            a_valid[i] = (bt >= 0);
            for (int l = 0; l < LANES; l++)
                a_data[(i*LANES+l)*W +: W] = (bt >= 0 && bt < BEATS) ?
                    W'(amat[i][bt*LANES+l]) : W'(127);
        end
        for (int j = 0; j < COLS; j++) begin
            int bt;
            bt = beat_at(t, j, extra, gap_at, gap_len);
            b_valid[j] = (bt >= 0);
            for (int l = 0; l < LANES; l++)
                b_data[(j*LANES+l)*W +: W] = (bt >= 0 && bt < BEATS) ?
                    W'(bmat[bt*LANES+l][j]) : W'(-100);
        end
    endtask

    // One job: start, skewed feed, then every drained row checked in its cycle.
    task automatic run_job(input string tag, input int extra, input int gap_at,
                           input int gap_len, input bit start_in_drain);
        int t0;
        int gl;
        gl = (gap_at < BEATS) ? gap_len : 0;
        t0 = ROWS + COLS + BEATS - 2 + gl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {"R9 busy after start ", tag}, busy, 1);
        for (int t = 0; t <= t0 + ROWS + 1; t++) begin
            drive(t, extra, gap_at, gap_len, start_in_drain ? t0 + 1 : -1);
            @(negedge clk);
            if (t >= t0 && t < t0 + ROWS) begin
                int r;
                r = ROWS - 1 - (t - t0);
                check(out_valid == 1'b1, {"R3 out_valid due ", tag}, out_valid, 1);
                check(out_row == ROW_W'(r), {"R4 row order ", tag}, out_row, r);
                for (int j = 0; j < COLS; j++) begin
                    longint sum;
                    logic [ACC_W-1:0] expb;
                    sum = 0;
                    for (int k = 0; k < K; k++) sum += longint'(amat[r][k]) * bmat[k][j];
                    expb = ACC_W'(sum);
                    check(out_data[j*ACC_W +: ACC_W] == expb, {"R2 result ", tag},
                          longint'($signed(out_data[j*ACC_W +: ACC_W])), sum);
                end
            end else begin
                check(out_valid == 1'b0, {"R4 no stray out_valid ", tag}, out_valid, 0);
            end
        end
        start = 1'b0;
        a_valid = '0;
        b_valid = '0;
        check(busy == 1'b0, {"R9 idle after drain ", tag}, busy, 0);
        @(negedge clk);
        check(out_valid == 1'b0 && busy == 1'b0, {"R8 no job after ignored start ", tag},
              {out_valid, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0, "R1 in reset", {busy, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0, "R1 after reset", {busy, out_valid}, 0);

        fill(0); run_job("random_a", 0, 99, 0, 1'b0);      // R2 R3 R4
        fill(0); run_job("random_b_R5", 0, 99, 0, 1'b0);   // R5: follow-on job
        fill(1); run_job("extreme_neg", 0, 99, 0, 1'b0);   // R2 no overflow
        fill(2); run_job("extreme_mix", 0, 99, 0, 1'b0);   // R2
        fill(0); run_job("surplus_R7", 2, 99, 0, 1'b0);    // R7
        fill(0); run_job("bubble_R6", 0, 1, 2, 1'b0);      // R6
        fill(0); run_job("start_in_drain_R8", 0, 99, 0, 1'b1); // R8

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule